// File: doc/BRIEF.md
# Three-Port Pin Interrupt Controller

This block turns three 8-bit groups of input pins into interrupt requests. For each pin, software chooses two things: whether it reacts to a level or to an edge, and whether it reacts to the low/falling side or the high/rising side. Each pin also has an enable bit. An optional debounce filter can be switched on for each pin; it accepts a new input level only after that level has stayed put for a set number of clock-enable ticks.

Every input passes through a two-flop synchroniser. In edge mode, a detected transition sets a sticky flag. The flag stays set until software writes a one to that pin's bit in the port's clear register. The status of the first two ports is ORed into a single shared request line. The third port drives one request line per pin.

Access is through a byte-wide register bus with single-cycle writes and combinational reads. Each port has a window of 16 addresses. The port index is taken from address bits [5:4], and the register is selected by bits [3:0].

Top module: `gpio_int_unit`

## Requirements
- R1: After reset, every configuration register reads 0x00, every status reads 0x00, `irqPins` is 0 and `irqCombined` is 0.
- R2: Port p (0..2) uses base address p*0x10. The register offsets are: 0x0 edge-select, 0x1 polarity, 0x2 clear, 0x3 enable, 0x4 debounce-enable, 0x5 status. The first, second, fourth and fifth registers read back what was written. The clear register always reads 0x00. The status register is read-only, and writes to it have no effect.
- R3: When an edge-select bit is 0, the pin is level-sensitive. Its status bit is 1 while the synchronised pin equals its polarity bit (polarity 1 = high active, polarity 0 = low active).
- R4: When an edge-select bit is 1, a transition in the polarity's direction (1 = rising, 0 = falling) sets the pin's status bit. The bit stays set after the pin returns to its earlier level.
- R5: Writing the clear register clears the latched edge of every pin whose data bit is 1. Pins whose data bit is 0 keep their latched edge.
- R6: A pin whose enable bit is 0 never shows status. Clearing the enable bit also discards any latched edge, so setting the bit again does not bring the old edge back.
- R7: Rewriting edge-select or polarity while a pin is disabled, then enabling it with its input steady, sets no latched edge.
- R8: With debounce off, a pin change made between clock edges first shows in a level-mode status on the third rising clock edge after the change, and not on the second.
- R9: With debounce on, a changed level is accepted on the DEB_TICKS-th consecutive tick (cycle with `tickEn` high) during which it differs from the accepted level. A shorter pulse is ignored, and cycles with `tickEn` low do not advance the count.
- R10: `irqCombined` is the OR of all status bits of ports 0 and 1. `irqPins[i]` is status bit i of port 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Debounce time-base tick |
| pinsA | input | 8 | Port 0 pin inputs (asynchronous) |
| pinsB | input | 8 | Port 1 pin inputs (asynchronous) |
| pinsC | input | 8 | Port 2 pin inputs (asynchronous) |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register byte address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data |
| irqCombined | output | 1 | Shared request for ports 0 and 1 |
| irqPins | output | 8 | Per-pin requests of port 2 |

## Verification
The bench builds the block with DEB_TICKS set to 3 instead of the default 16. This puts the debounce acceptance boundary only a few cycles away, so the checks can land exactly on the tick that accepts a level and on the tick just before it. It also lets a one-cycle glitch and a stalled tick stream be tried within a short run. ADDR_W keeps its default of 8, which maps all three port windows.

// File: rtl/gpio_int_pkg.sv
package gpio_int_pkg;
  localparam int PORT_W   = 8;
  localparam int PORT_CNT = 3;

  typedef struct packed {
    logic [PORT_W-1:0] edgeSel;
    logic [PORT_W-1:0] highSel;
    logic [PORT_W-1:0] enable;
    logic [PORT_W-1:0] deb;
  } portCfg_t;

  typedef struct packed {
    logic [PORT_CNT-1:0] eoiWr;
    logic [PORT_W-1:0]   eoiMask;
  } strobe_t;

  typedef enum logic [3:0] {
    REG_EDGE = 4'h0,
    REG_HIGH = 4'h1,
    REG_EOI  = 4'h2,
    REG_EN   = 4'h3,
    REG_DEB  = 4'h4,
    REG_STAT = 4'h5
  } regSel_e;
endpackage

// File: rtl/gpio_int_ctrl.sv
module gpio_int_ctrl
  import gpio_int_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             busWrEn,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [PORT_W-1:0]                busWrData,
  input  logic [PORT_CNT-1:0][PORT_W-1:0]  portStat,
  output portCfg_t [PORT_CNT-1:0]          cfg,
  output strobe_t                          strobe,
  output logic [PORT_W-1:0]                busRdData
);
  localparam int PORT_SEL_W = (PORT_CNT > 1) ? $clog2(PORT_CNT) : 1;
  localparam int PORT_LSB   = 4;

  logic [PORT_SEL_W-1:0] portIdx;
  regSel_e               regField;
  logic                  addrHit;

  assign portIdx  = busAddr[PORT_LSB +: PORT_SEL_W];
  assign regField = regSel_e'(busAddr[3:0]);
  assign addrHit  = (busAddr[ADDR_W-1:PORT_LSB+PORT_SEL_W] == '0) &&
                    (int'(portIdx) < PORT_CNT);

  for (genvar p = 0; p < PORT_CNT; p++) begin : g_port
    portCfg_t cfgReg;
    logic     portHit;
    assign portHit = addrHit && (portIdx == PORT_SEL_W'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfgReg <= '0;
      end else if (busWrEn && portHit) begin
        case (regField)
          REG_EDGE: cfgReg.edgeSel <= busWrData;
          REG_HIGH: cfgReg.highSel <= busWrData;
          REG_EN:   cfgReg.enable  <= busWrData;
          REG_DEB:  cfgReg.deb     <= busWrData;
          default:  ;
        endcase
      end
    end
    assign cfg[p] = cfgReg;
  end

  always_comb begin
    strobe.eoiMask = busWrData;
    strobe.eoiWr   = '0;
    busRdData      = '0;
    for (int p = 0; p < PORT_CNT; p++) begin
      if (addrHit && portIdx == PORT_SEL_W'(p)) begin
        strobe.eoiWr[p] = busWrEn && (regField == REG_EOI);
        case (regField)
          REG_EDGE: busRdData = cfg[p].edgeSel;
          REG_HIGH: busRdData = cfg[p].highSel;
          REG_EN:   busRdData = cfg[p].enable;
          REG_DEB:  busRdData = cfg[p].deb;
          REG_STAT: busRdData = portStat[p];
          default:  busRdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_int_lane.sv
module gpio_int_lane
  import gpio_int_pkg::*;
#(
  parameter int DEB_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic [PORT_W-1:0] pinIn,
  input  portCfg_t          cfg,
  input  logic              eoiWr,
  input  logic [PORT_W-1:0] eoiMask,
  output logic [PORT_W-1:0] stat
);
  localparam int CNT_W = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_TICKS - 1);

  logic [PORT_W-1:0] syncA, syncB, filt, prevLine, latchQ;
  logic [PORT_W-1:0] rise, fall, edgeHit, levelAct, clrMask;

  // two-flop synchroniser
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  // per-pin debounce filter: bypassed when its enable bit is low
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    logic [CNT_W-1:0] cnt;
    logic             filtBit;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt     <= '0;
        filtBit <= 1'b0;
      end else if (!cfg.deb[i]) begin
        cnt     <= '0;
        filtBit <= syncB[i];
      end else if (syncB[i] == filtBit) begin
        cnt <= '0;
      end else if (tickEn) begin
        if (cnt == CNT_LAST) begin
          cnt     <= '0;
          filtBit <= syncB[i];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign filt[i] = filtBit;
  end

  assign rise     = filt & ~prevLine;
  assign fall     = ~filt & prevLine;
  assign edgeHit  = cfg.enable & cfg.edgeSel &
                    ((cfg.highSel & rise) | (~cfg.highSel & fall));
  assign clrMask  = eoiWr ? eoiMask : '0;
  assign levelAct = ~(filt ^ cfg.highSel);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLine <= '0;
      latchQ   <= '0;
    end else begin
      prevLine <= filt;
      latchQ   <= cfg.enable & cfg.edgeSel & ((latchQ & ~clrMask) | edgeHit);
    end
  end

  assign stat = cfg.enable & ((cfg.edgeSel & latchQ) | (~cfg.edgeSel & levelAct));
endmodule

// File: rtl/gpio_int_unit.sv
module gpio_int_unit
  import gpio_int_pkg::*;
#(
  parameter int DEB_TICKS = 16,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic [PORT_W-1:0] pinsA,
  input  logic [PORT_W-1:0] pinsB,
  input  logic [PORT_W-1:0] pinsC,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWrData,
  output logic [PORT_W-1:0] busRdData,
  output logic              irqCombined,
  output logic [PORT_W-1:0] irqPins
);
  logic [PORT_CNT-1:0][PORT_W-1:0] pinBus;
  logic [PORT_CNT-1:0][PORT_W-1:0] portStat;
  portCfg_t [PORT_CNT-1:0]         portCfg;
  strobe_t                         strobe;

  assign pinBus = {pinsC, pinsB, pinsA};

  gpio_int_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .portStat(portStat), .cfg(portCfg),
    .strobe(strobe), .busRdData(busRdData)
  );

  for (genvar p = 0; p < PORT_CNT; p++) begin : g_lane
    gpio_int_lane #(.DEB_TICKS(DEB_TICKS)) i_lane (
      .clk(clk), .rst(rst), .tickEn(tickEn), .pinIn(pinBus[p]),
      .cfg(portCfg[p]), .eoiWr(strobe.eoiWr[p]), .eoiMask(strobe.eoiMask),
      .stat(portStat[p])
    );
  end

  assign irqCombined = |(portStat[0] | portStat[1]);
  assign irqPins     = portStat[2];
endmodule

// File: rtl/gpio_int_chk.sv
module gpio_int_chk
  import gpio_int_pkg::*;
(
  input logic                            clk,
  input logic                            rst,
  input portCfg_t [PORT_CNT-1:0]         cfg,
  input logic [PORT_CNT-1:0][PORT_W-1:0] stat,
  input strobe_t                         strobe,
  input logic                            irqCombined,
  input logic [PORT_W-1:0]               irqPins
);
  for (genvar p = 0; p < PORT_CNT; p++) begin : g_chk
    logic [PORT_W-1:0] eoiEff;
    assign eoiEff = strobe.eoiWr[p] ? strobe.eoiMask : '0;

    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (stat[p] & ~cfg[p].enable) == '0);

    // R7
    no_spurious_edge_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(~cfg[p].enable) & cfg[p].enable & cfg[p].edgeSel & stat[p]) == '0);

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(stat[p] & cfg[p].edgeSel & cfg[p].enable & ~eoiEff)
        & cfg[p].edgeSel & cfg[p].enable & ~stat[p]) == '0);
  end

  // R10
  combined_src_chk: assert property (@(posedge clk) disable iff (rst)
    irqCombined |-> |(cfg[0].enable | cfg[1].enable));

  // R10
  pin_src_chk: assert property (@(posedge clk) disable iff (rst)
    (irqPins & ~cfg[2].enable) == '0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irqPins == '0 && !irqCombined));
endmodule

bind gpio_int_unit gpio_int_chk i_chk (
  .clk(clk), .rst(rst), .cfg(portCfg), .stat(portStat), .strobe(strobe),
  .irqCombined(irqCombined), .irqPins(irqPins)
);

// File: tb/test_gpio_int_unit.sv
module test_gpio_int_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn = 1'b1;
  logic [7:0] pinsA = '0, pinsB = '0, pinsC = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busAddr = '0, busWrData = '0;
  logic [7:0] busRdData;
  logic       irqCombined;
  logic [7:0] irqPins;
  int         checks = 0;
  int         fails = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  gpio_int_unit #(.DEB_TICKS(3), .ADDR_W(8)) i_gpio_int_unit (
    .clk(clk), .rst(rst), .tickEn(tickEn), .pinsA(pinsA), .pinsB(pinsB),
    .pinsC(pinsC), .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .irqCombined(irqCombined), .irqPins(irqPins)
  );

  typedef struct packed {
    logic [7:0] base;
    logic [7:0] pins;
    logic [7:0] edgeSel;
    logic [7:0] highSel;
    logic [7:0] en;
    logic [7:0] expStat;
    logic       expComb;
  } vec_t;

  // level-mode vectors (R3, R6, R10)
  localparam vec_t VECS [7] = '{
    '{8'h00, 8'hF0, 8'h00, 8'hFF, 8'hFF, 8'hF0, 1'b1},
    '{8'h00, 8'hF0, 8'h00, 8'h00, 8'hFF, 8'h0F, 1'b1},
    '{8'h00, 8'hF0, 8'h00, 8'h0F, 8'hFF, 8'h00, 1'b0},
    '{8'h00, 8'h3C, 8'h00, 8'hF0, 8'h0F, 8'h03, 1'b1},
    '{8'h00, 8'hA5, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0},
    '{8'h00, 8'hA5, 8'h00, 8'hFF, 8'h81, 8'h81, 1'b1},
    '{8'h10, 8'h0F, 8'h00, 8'hFF, 8'hFF, 8'h0F, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = v;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearPort(input logic [7:0] base);
    busWrite(base + 8'h3, 8'h00);
    busWrite(base + 8'h0, 8'h00);
    busWrite(base + 8'h1, 8'h00);
    busWrite(base + 8'h4, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    busRead(8'h00, rd); chk("R1 edge-select", rd, 8'h00);
    busRead(8'h13, rd); chk("R1 enable", rd, 8'h00);
    busRead(8'h24, rd); chk("R1 debounce", rd, 8'h00);
    busRead(8'h25, rd); chk("R1 status", rd, 8'h00);
    chk("R1 irqPins", irqPins, 8'h00);
    chk("R1 irqCombined", {7'd0, irqCombined}, 8'h00);

    // R2 readback and read-only status
    busWrite(8'h10, 8'h5A); busRead(8'h10, rd); chk("R2 edge-select readback", rd, 8'h5A);
    busWrite(8'h11, 8'hC3); busRead(8'h11, rd); chk("R2 polarity readback", rd, 8'hC3);
    busWrite(8'h14, 8'h81); busRead(8'h14, rd); chk("R2 debounce readback", rd, 8'h81);
    busWrite(8'h13, 8'h00); busRead(8'h13, rd); chk("R2 enable readback", rd, 8'h00);
    busWrite(8'h15, 8'hFF); busRead(8'h15, rd); chk("R2 status read-only", rd, 8'h00);
    clearPort(8'h10);

    // table walk: level mode
    foreach (VECS[k]) begin
      if (VECS[k].base == 8'h00) pinsA = VECS[k].pins;
      else pinsB = VECS[k].pins;
      busWrite(VECS[k].base + 8'h0, VECS[k].edgeSel);
      busWrite(VECS[k].base + 8'h1, VECS[k].highSel);
      busWrite(VECS[k].base + 8'h3, VECS[k].en);
      waitCyc(6);
      busRead(VECS[k].base + 8'h5, rd);
      chk("R3 level status", rd, VECS[k].expStat);
      chk("R10 combined", {7'd0, irqCombined}, {7'd0, VECS[k].expComb});
    end
    pinsA = '0; pinsB = '0;
    clearPort(8'h00);
    clearPort(8'h10);
    waitCyc(6);

    // R4 rising on pin0, falling on pin1
    busWrite(8'h00, 8'h03);
    busWrite(8'h01, 8'h01);
    busWrite(8'h03, 8'h03);
    waitCyc(6);
    busRead(8'h05, rd); chk("R4 idle", rd, 8'h00);
    pinsA = 8'h03; waitCyc(6);
    busRead(8'h05, rd); chk("R4 rising", rd, 8'h01);
    pinsA = 8'h00; waitCyc(6);
    busRead(8'h05, rd); chk("R4 falling and held", rd, 8'h03);
    chk("R10 combined from port0", {7'd0, irqCombined}, 8'h01);

    // R5 write-one-to-clear
    busWrite(8'h02, 8'h01); waitCyc(1);
    busRead(8'h05, rd); chk("R5 selective clear", rd, 8'h02);
    busRead(8'h02, rd); chk("R2 clear reads zero", rd, 8'h00);
    busWrite(8'h02, 8'h02); waitCyc(1);
    busRead(8'h05, rd); chk("R5 second clear", rd, 8'h00);
    chk("R10 combined low", {7'd0, irqCombined}, 8'h00);

    // R6 disable discards latched edge
    pinsA = 8'h01; waitCyc(6);
    busRead(8'h05, rd); chk("R6 latched", rd, 8'h01);
    busWrite(8'h03, 8'h02);
    busRead(8'h05, rd); chk("R6 disabled hides", rd, 8'h00);
    busWrite(8'h03, 8'h03); waitCyc(3);
    busRead(8'h05, rd); chk("R6 old edge gone", rd, 8'h00);

    // R7 type changes while disabled
    busWrite(8'h03, 8'h00);
    busWrite(8'h00, 8'h00);
    busWrite(8'h01, 8'h00);
    busWrite(8'h00, 8'h01);
    busWrite(8'h01, 8'h01);
    busWrite(8'h01, 8'h00);
    busWrite(8'h03, 8'h01); waitCyc(6);
    busRead(8'h05, rd); chk("R7 no spurious edge", rd, 8'h00);
    pinsA = 8'h00; waitCyc(6);
    busRead(8'h05, rd); chk("R7 falling after enable", rd, 8'h01);
    clearPort(8'h00);

    // R8 synchroniser latency on port2 pin0, level high
    busWrite(8'h21, 8'h03);
    busWrite(8'h24, 8'h02);
    busWrite(8'h23, 8'h03);
    waitCyc(6);
    @(negedge clk); pinsC[0] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R8 not after two edges", irqPins & 8'h01, 8'h00);
    @(posedge clk); #1;
    chk("R8 visible on third edge", irqPins & 8'h01, 8'h01);
    busRead(8'h25, rd); chk("R10 irqPins matches status", irqPins, rd);

    // R9 debounce on port2 pin1
    @(negedge clk); pinsC[1] = 1'b1;
    @(negedge clk); pinsC[1] = 1'b0;
    waitCyc(10);
    chk("R9 glitch ignored", irqPins & 8'h02, 8'h00);
    @(negedge clk); pinsC[1] = 1'b1;
    repeat (4) @(posedge clk); #1;
    chk("R9 not before DEB_TICKS", irqPins & 8'h02, 8'h00);
    @(posedge clk); #1;
    chk("R9 accepted at DEB_TICKS", irqPins & 8'h02, 8'h02);
    @(negedge clk); tickEn = 1'b0; pinsC[1] = 1'b0;
    waitCyc(10);
    chk("R9 ticks stalled", irqPins & 8'h02, 8'h02);
    @(negedge clk); tickEn = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk("R9 resume count", irqPins & 8'h02, 8'h02);
    @(posedge clk); #1;
    chk("R9 low accepted", irqPins & 8'h02, 8'h00);
    chk("R10 port2 not in combined", {7'd0, irqCombined}, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule